// File: doc/BRIEF.md
# SDRAM Read Latency Burst Model

This block is a cycle-accurate stand-in for the read side of a synchronous DRAM. A memory controller under test can drive it directly. It takes activate, read and precharge commands, each carrying a bank, row and column. It tracks which row is open in each of its eight banks. For every legal read it streams a burst of data words, with a valid flag, after a runtime-programmable number of clock cycles.

Bursts are four or eight words long. Each burst begins with the requested word and then wraps around inside the aligned group of columns. Reads to different banks may overlap their latency, so that one burst streams out while the next read is still waiting.

The block flags two kinds of bad read, and returns no data for either. The first is a read that targets a closed bank or the wrong row. The second is a read whose burst would land on output cycles already taken by an earlier burst.

Top module: `sdram_rd_model`

## Requirements
- R1: After reset, every bank is closed, `rdValid`, `rdData`, `errRow` and `errConflict` are 0, the latency is 3 cycles and the burst length is 4.
- R2: A read sampled at clock edge k shows its first word on `rdData` with `rdValid` high from edge k+CL, where CL is the current latency setting (2 to 8).
- R3: The remaining words of a burst follow on consecutive edges, BL words in all. `rdValid` is low on every cycle that carries no burst word, and `rdData` is 0 there.
- R4: Word j of a burst (j from 0) comes from column (C & ~(BL-1)) | ((C + j) mod BL), where C is the column of the read.
- R5: A configuration write (`cfgWe`) takes effect at its clock edge only when all of these hold: `cfgCl` is in 2..8, no read command is present on that edge, and no burst is in flight. `cfgBl8`=1 selects BL=8 and 0 selects BL=4. Any other configuration write is ignored.
- R6: The word for bank B and column C equals ((I*0x0901) XOR 0x3C00 XOR (C>>3)), taken to 16 bits, where I = B*8 + (C mod 8).
- R7: A read to a bank with no open row, or to a row other than the open one, raises `errRow` for exactly the cycle after its edge, and produces no data.
- R8: Activate opens the given row in the given bank, replacing any row already open there. Precharge closes the bank.
- R9: A legal read whose first word would fall on or before the last word of a burst already scheduled raises `errConflict` for one cycle and is dropped. The earlier burst is unaffected.
- R10: A read to another bank issued exactly BL cycles after the previous accepted read is accepted, and its words follow the earlier burst with no gap.
- R11: Command encoding on `cmd`: 0 = no operation, 1 = activate, 2 = read, 3 = precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | Command code (R11) |
| cmdBank | input | 3 | Bank of the command |
| cmdRow | input | 14 | Row for activate and the row check of a read |
| cmdCol | input | 10 | Column of a read |
| cfgWe | input | 1 | Configuration write strobe |
| cfgCl | input | 4 | Requested latency in cycles |
| cfgBl8 | input | 1 | 1 selects 8-word bursts, 0 selects 4-word bursts |
| rdData | output | 16 | Burst data word |
| rdValid | output | 1 | High on each cycle that carries a burst word |
| errRow | output | 1 | One-cycle pulse for a read to a closed bank or the wrong row |
| errConflict | output | 1 | One-cycle pulse for a read dropped for output overlap |

## Verification
The assertions take for granted that `cmd` is sampled cleanly on each edge and that only the four defined codes appear. They also rely on the guard in the configuration path: latency and burst length cannot move while a burst is in flight, so the latency pipeline never has two reads claiming the same stage. The stimulus drives commands and configuration writes on the falling edge, always one command per edge. It deliberately offers configuration writes while reads are pending, and with out-of-range latencies, so that the guard itself is exercised rather than merely assumed.

// File: rtl/sdrm_pkg.sv
`timescale 1ns/1ps
package sdrm_pkg;
  localparam int BANK_W   = 3;
  localparam int ROW_W    = 14;
  localparam int COL_W    = 10;
  localparam int GRP_W    = 3;   // column bits inside the largest burst group
  localparam int COLHI_W  = COL_W - GRP_W;
  localparam int CL_W     = 4;
  localparam int MIN_CL   = 2;
  localparam int MAX_CL   = 8;
  localparam int RESET_CL = 3;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_PRE = 2'd3
  } cmdKind_e;

  // accepted read travelling through the latency pipeline
  typedef struct packed {
    logic               valid;
    logic               bl8;
    logic [BANK_W-1:0]  bank;
    logic [COLHI_W-1:0] colHi;
    logic [GRP_W-1:0]   col;
  } launch_t;

  // per-cycle strobe from control to datapath
  typedef struct packed {
    logic               emit;
    logic [BANK_W-1:0]  bank;
    logic [COLHI_W-1:0] colHi;
    logic [GRP_W-1:0]   col;
  } strobe_t;
endpackage

// File: rtl/sdrm_ctrl.sv
`timescale 1ns/1ps
module sdrm_ctrl
  import sdrm_pkg::*;
#(
  parameter int NBANK = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cmd,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic [ROW_W-1:0]  cmdRow,
  input  logic [COL_W-1:0]  cmdCol,
  input  logic              cfgWe,
  input  logic [CL_W-1:0]   cfgCl,
  input  logic              cfgBl8,
  output launch_t           launch,
  output logic [CL_W-1:0]   curCl,
  output logic              errRow,
  output logic              errConflict
);
  localparam int RESV_W = $clog2(MAX_CL + 8 + 1);

  cmdKind_e          cmdKind;
  logic [NBANK-1:0]  rowOpen;
  logic [ROW_W-1:0]  openRow [NBANK];
  logic              curBl8;
  logic [RESV_W-1:0] resv;       // edges still reserved on the output, from the next edge
  logic [RESV_W-1:0] burstLen;
  logic              isRead, rowHit, busBusy, acceptRd, cfgOk;

  assign cmdKind  = cmdKind_e'(cmd);
  assign isRead   = (cmdKind == CMD_RD);
  assign rowHit   = rowOpen[cmdBank] && (openRow[cmdBank] == cmdRow);
  assign burstLen = curBl8 ? RESV_W'(8) : RESV_W'(4);
  assign busBusy  = resv > RESV_W'(curCl);
  assign acceptRd = isRead && rowHit && !busBusy;
  assign cfgOk    = cfgWe && !isRead && (resv == '0) &&
                    (cfgCl >= CL_W'(MIN_CL)) && (cfgCl <= CL_W'(MAX_CL));

  always_comb begin
    launch.valid = acceptRd;
    launch.bl8   = curBl8;
    launch.bank  = cmdBank;
    launch.colHi = cmdCol[COL_W-1:GRP_W];
    launch.col   = cmdCol[GRP_W-1:0];
  end

  // open-row table
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowOpen <= '0;
      for (int i = 0; i < NBANK; i++) openRow[i] <= '0;
    end else begin
      case (cmdKind)
        CMD_ACT: begin
          rowOpen[cmdBank] <= 1'b1;
          openRow[cmdBank] <= cmdRow;
        end
        CMD_PRE: rowOpen[cmdBank] <= 1'b0;
        default: ;
      endcase
    end
  end

  // configuration, output reservation and error pulses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCl       <= CL_W'(RESET_CL);
      curBl8      <= 1'b0;
      resv        <= '0;
      errRow      <= 1'b0;
      errConflict <= 1'b0;
    end else begin
      if (cfgOk) begin
        curCl  <= cfgCl;
        curBl8 <= cfgBl8;
      end
      if (acceptRd)          resv <= RESV_W'(curCl) + burstLen - RESV_W'(1);
      else if (resv != '0)   resv <= resv - RESV_W'(1);
      errRow      <= isRead && !rowHit;
      errConflict <= isRead && rowHit && busBusy;
    end
  end

  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(errRow && errConflict)); // R7
  AST_CL_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (curCl >= CL_W'(MIN_CL)) && (curCl <= CL_W'(MAX_CL))); // R5
  AST_CL_HELD_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (resv != '0) |=> $stable(curCl)); // R5
  AST_BL_HELD_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (resv != '0) |=> $stable(curBl8)); // R5
endmodule

// File: rtl/sdrm_latpipe.sv
`timescale 1ns/1ps
module sdrm_latpipe
  import sdrm_pkg::*;
#(
  parameter int DEPTH = MAX_CL - MIN_CL + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  launch_t         launchIn,
  input  logic [CL_W-1:0] curCl,
  output launch_t         head
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int LW    = $bits(launch_t);

  launch_t [DEPTH-1:0] stg;
  launch_t [DEPTH-1:0] shifted;
  logic [IDX_W-1:0]    wrIdx;

  // a read enters CL-2 stages from the head so that its first word leaves at edge k+CL
  assign wrIdx   = IDX_W'(curCl - CL_W'(MIN_CL));
  assign shifted = {LW'(0), stg[DEPTH-1:1]};
  assign head    = stg[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stg <= '0;
    end else begin
      stg <= shifted;
      if (launchIn.valid) stg[wrIdx] <= launchIn;
    end
  end

  AST_STAGE_FREE: assert property (@(posedge clk) disable iff (!rstN)
    launchIn.valid |-> !shifted[wrIdx].valid); // R2
endmodule

// File: rtl/sdrm_burst.sv
`timescale 1ns/1ps
module sdrm_burst
  import sdrm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  launch_t head,
  output strobe_t strobe
);
  logic               active, bl8;
  logic [BANK_W-1:0]  bank;
  logic [COLHI_W-1:0] colHi;
  logic [GRP_W-1:0]   crit, cnt, lastIdx, mask;

  assign lastIdx = bl8 ? GRP_W'(7) : GRP_W'(3);
  assign mask    = bl8 ? GRP_W'(7) : GRP_W'(3);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      bl8    <= 1'b0;
      bank   <= '0;
      colHi  <= '0;
      crit   <= '0;
      cnt    <= '0;
    end else if (head.valid) begin
      active <= 1'b1;
      bl8    <= head.bl8;
      bank   <= head.bank;
      colHi  <= head.colHi;
      crit   <= head.col;
      cnt    <= '0;
    end else if (active) begin
      if (cnt == lastIdx) active <= 1'b0;
      cnt <= cnt + GRP_W'(1);
    end
  end

  // critical word first, wrapping inside the aligned group
  always_comb begin
    strobe.emit  = active;
    strobe.bank  = bank;
    strobe.colHi = colHi;
    strobe.col   = (crit & ~mask) | ((crit + cnt) & mask);
  end

  AST_NO_BURST_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    (head.valid && active) |-> (cnt == lastIdx)); // R9
  AST_LOAD_STARTS_EMIT: assert property (@(posedge clk) disable iff (!rstN)
    head.valid |=> strobe.emit); // R3
endmodule

// File: rtl/sdrm_dpath.sv
`timescale 1ns/1ps
module sdrm_dpath
  import sdrm_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int INIT_MUL = 32'h0901,
  parameter int INIT_XOR = 32'h3C00
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  localparam int AW     = BANK_W + GRP_W;
  localparam int NWORDS = 1 << AW;

  logic [DATA_W-1:0] mem [NWORDS];
  logic [AW-1:0]     idx;

  function automatic logic [DATA_W-1:0] seedWord(input int i);
    return DATA_W'(i * INIT_MUL) ^ DATA_W'(INIT_XOR);
  endfunction

  assign idx = {strobe.bank, strobe.col};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= seedWord(i);
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.emit;
      rdData  <= strobe.emit ? (mem[idx] ^ DATA_W'(strobe.colHi)) : '0;
    end
  end

  AST_VALID_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emit |=> rdValid); // R3
  AST_QUIET_FOLLOWS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.emit |=> !rdValid); // R3
endmodule

// File: rtl/sdram_rd_model.sv
`timescale 1ns/1ps
module sdram_rd_model
  import sdrm_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int INIT_MUL = 32'h0901,
  parameter int INIT_XOR = 32'h3C00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cmd,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic [ROW_W-1:0]  cmdRow,
  input  logic [COL_W-1:0]  cmdCol,
  input  logic              cfgWe,
  input  logic [CL_W-1:0]   cfgCl,
  input  logic              cfgBl8,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              errRow,
  output logic              errConflict
);
  launch_t         launch, head;
  strobe_t         strobe;
  logic [CL_W-1:0] curCl;

  sdrm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cmdBank(cmdBank), .cmdRow(cmdRow),
    .cmdCol(cmdCol), .cfgWe(cfgWe), .cfgCl(cfgCl), .cfgBl8(cfgBl8),
    .launch(launch), .curCl(curCl), .errRow(errRow), .errConflict(errConflict)
  );

  sdrm_latpipe u_latpipe (
    .clk(clk), .rstN(rstN), .launchIn(launch), .curCl(curCl), .head(head)
  );

  sdrm_burst u_burst (
    .clk(clk), .rstN(rstN), .head(head), .strobe(strobe)
  );

  sdrm_dpath #(.DATA_W(DATA_W), .INIT_MUL(INIT_MUL), .INIT_XOR(INIT_XOR)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: tb/sdram_rd_model_test.sv
`timescale 1ns/1ps
module sdram_rd_model_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  cmd = 2'd0;
  logic [2:0]  cmdBank = '0;
  logic [13:0] cmdRow = '0;
  logic [9:0]  cmdCol = '0;
  logic        cfgWe = 1'b0;
  logic [3:0]  cfgCl = '0;
  logic        cfgBl8 = 1'b0;
  logic [15:0] rdData;
  logic        rdValid, errRow, errConflict;

  sdram_rd_model uut (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cmdBank(cmdBank), .cmdRow(cmdRow),
    .cmdCol(cmdCol), .cfgWe(cfgWe), .cfgCl(cfgCl), .cfgBl8(cfgBl8),
    .rdData(rdData), .rdValid(rdValid), .errRow(errRow), .errConflict(errConflict)
  );

  always #2 clk = ~clk;   // 250 MHz

  typedef struct {
    int          edgeNo;
    logic [15:0] data;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int  edgeCnt = 0;
  int  checks = 0;
  int  fails = 0;
  bit  running = 0;
  bit  done = 0;
  int  modelCl = 3;
  int  modelBl = 4;

  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] wordOf(input int bank, input int col);
    int idx = bank * 8 + (col % 8);
    return 16'((idx * 32'h0901) ^ 32'h3C00 ^ (col >> 3));
  endfunction

  // driver side of the scoreboard: expected words for an accepted read at edge e
  task automatic pushBurst(input int e, input int bank, input int col, input string tag);
    for (int j = 0; j < modelBl; j++) begin
      int c = (col & ~(modelBl - 1)) | ((col + j) % modelBl);
      expQ.push_back('{e + modelCl + j, wordOf(bank, c), tag});
    end
  endtask

  // one command on the next edge; returns at the falling edge after it (R11 encodings)
  task automatic doCmd(input int c, input int bank, input int row, input int col,
                       input bit eRow, input bit eConf, input string tag);
    int e = edgeCnt + 1;
    cmd = 2'(c); cmdBank = 3'(bank); cmdRow = 14'(row); cmdCol = 10'(col);
    @(negedge clk);
    cmd = 2'd0;
    if (c == 2) begin
      check(errRow == eRow, tag, "errRow", int'(errRow), int'(eRow));
      check(errConflict == eConf, tag, "errConflict", int'(errConflict), int'(eConf));
      if (!eRow && !eConf) pushBurst(e, bank, col, tag);
    end
  endtask

  task automatic setCfg(input int cl, input bit bl8, input bit taken);
    cfgWe = 1'b1; cfgCl = 4'(cl); cfgBl8 = bl8;
    @(negedge clk);
    cfgWe = 1'b0;
    if (taken) begin
      modelCl = cl;
      modelBl = bl8 ? 8 : 4;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (running) begin
      if (expQ.size() > 0 && expQ[0].edgeNo == edgeCnt) begin
        check(rdValid === 1'b1, expQ[0].tag, "rdValid", int'(rdValid), 1);
        check(rdData === expQ[0].data, expQ[0].tag, "rdData", int'(rdData), int'(expQ[0].data));
        void'(expQ.pop_front());
      end else begin
        check(rdValid === 1'b0, "R3", "rdValid outside burst", int'(rdValid), 0);
        check(rdData === 16'h0, "R3", "rdData outside burst", int'(rdData), 0);
      end
    end
  end

  task automatic finishRun;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finishRun();
    end
  end

  initial begin
    idle(4);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rdValid == 1'b0, "R1", "rdValid", int'(rdValid), 0);
    check(rdData == 16'h0, "R1", "rdData", int'(rdData), 0);
    check(errRow == 1'b0, "R1", "errRow", int'(errRow), 0);
    check(errConflict == 1'b0, "R1", "errConflict", int'(errConflict), 0);
    running = 1;

    // R1 R7: banks start closed
    doCmd(2, 0, 'h123, 5, 1, 0, "R7");
    idle(6);
    // R8: open two banks, then critical-word-first read (R2 R4 R6)
    doCmd(1, 0, 'h123, 0, 0, 0, "R8");
    doCmd(1, 5, 'h007, 0, 0, 0, "R8");
    doCmd(2, 0, 'h123, 5, 0, 0, "R4");
    idle(8);
    doCmd(2, 5, 'h007, 'h3FE, 0, 0, "R6");
    idle(8);
    // R7: wrong row
    doCmd(2, 0, 'h124, 5, 1, 0, "R7");
    idle(6);
    // R9: second read two cycles later collides
    doCmd(2, 0, 'h123, 0, 0, 0, "R2");
    idle(1);
    doCmd(2, 5, 'h007, 1, 0, 1, "R9");
    idle(10);
    // R9: three cycles later still collides; R10: four cycles later streams seamlessly
    doCmd(2, 0, 'h123, 1, 0, 0, "R10");
    idle(2);
    doCmd(2, 5, 'h007, 2, 0, 1, "R9");
    doCmd(2, 5, 'h007, 6, 0, 0, "R10");
    idle(12);

    // R5: accepted configuration CL=5, BL=8
    setCfg(5, 1, 1);
    doCmd(2, 5, 'h007, 2, 0, 0, "R5");
    setCfg(2, 0, 0);            // R5: rejected while a burst is in flight
    idle(16);
    doCmd(2, 0, 'h123, 10, 0, 0, "R5");
    idle(16);
    setCfg(9, 0, 0);            // R5: out of range
    setCfg(1, 0, 0);            // R5: out of range
    doCmd(2, 0, 'h123, 3, 0, 0, "R5");
    idle(16);

    // R9 R10 at CL=2, BL=8: edge+7 collides, edge+8 is seamless
    setCfg(2, 1, 1);
    doCmd(2, 0, 'h123, 4, 0, 0, "R2");
    idle(6);
    doCmd(2, 5, 'h007, 1, 0, 1, "R9");
    doCmd(2, 5, 'h007, 7, 0, 0, "R10");
    idle(16);

    // R2: largest latency
    setCfg(8, 1, 1);
    doCmd(2, 5, 'h007, 0, 0, 0, "R2");
    idle(20);

    // R8: precharge closes, activate of a new row replaces
    setCfg(3, 0, 1);
    doCmd(3, 0, 0, 0, 0, 0, "R8");
    doCmd(2, 0, 'h123, 9, 1, 0, "R8");
    doCmd(1, 0, 'h200, 0, 0, 0, "R8");
    doCmd(2, 0, 'h123, 9, 1, 0, "R8");
    doCmd(2, 0, 'h200, 9, 0, 0, "R8");
    idle(12);
    doCmd(1, 5, 'h300, 0, 0, 0, "R8");
    doCmd(2, 5, 'h007, 0, 1, 0, "R8");
    idle(30);

    check(expQ.size() == 0, "R3", "words never delivered", expQ.size(), 0);
    done = 1;
    finishRun();
  end
endmodule